// File: doc/BRIEF.md
# Prioritised Interrupt Controller

This block gathers interrupt request lines from up to 63 sources and presents to the processor a single registered request. The request is a 3-bit level and the 6-bit number of the winning source. A level of zero means nothing is pending.

Slot 0 carries no source. Slots 1 to 7 are fixed-level external lines. Slots 8 to 63 are fully programmable: each has a 6-bit control value, a 3-bit level above a 3-bit priority.

Software reaches two mask words and sixteen control words through a small register bus with byte enables. Each source can be blocked by its own mask bit. A single mask-all bit blocks every source at once.

Arbitration takes the pending, unmasked source with the highest level. Within that level it takes the highest priority. Software is expected to give each active source a distinct level and priority pair. If two sources do share a pair, the lower source number wins, so the outcome stays deterministic.

Top module: `pic_top`

## Requirements
- R1: After reset, both mask words read 32'hFFFFFFFF, every programmable control byte reads 0, `irq_level` and `irq_src` are 0, and `rdata` is 0.
- R2: Source s is governed by mask bit s mod 32. Sources 0 to 31 use bus word 0 and sources 32 to 63 use bus word 1. A 1 blocks the source and a 0 lets it request.
- R3: Bit 0 of mask word 0 is mask-all. While it is 1, no source produces a request, whatever its own mask bit.
- R4: The control byte of source s is in bus word 16 + s/4, byte lane s mod 4 (bits 8*(s mod 4)+7 down to 8*(s mod 4)). Within the byte, bits 5:3 are the level and bits 2:0 are the priority. Bits 7:6 read as 0.
- R5: A programmable source whose level field is 0 never produces a request.
- R6: The winner is the eligible source with the highest level. Ties on level are broken by the highest priority, and ties on both are broken by the lowest source number.
- R7: `irq_level` and `irq_src` show the winner one clock after the inputs and registers that select it. They return to 0 one clock after the winning input drops or becomes masked, provided no other source is eligible.
- R8: Slot n, for n from 1 to 7, has level n and priority 4. Its control byte always reads {2'b00, n, 3'd4}, and writes to it are ignored.
- R9: Slot 0 never produces a request, and its control byte always reads 0.
- R10: A write changes only the byte lanes whose `be` bit is 1. `be[b]` enables bits 8b+7 down to 8b.
- R11: `rdata` carries the word at `addr` in the clock after a cycle with `rd_en` high, and 0 after any cycle without it. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 64 | Request lines, one per slot (bit 0 unused) |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Register word address |
| be | input | 4 | Byte enables for writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq_level | output | 3 | Level of the winning request, 0 when idle |
| irq_src | output | 6 | Source number of the winning request |

## Verification
The assertions rely on `irq_in` and the bus signals being settled before each rising edge and free of unknown values once reset has been applied. They also rely on reset being high at the first edge. The bench meets both conditions: it holds reset for several cycles from time zero and changes every input only on the falling clock edge.

The assertions do not assume unique level and priority pairs, because the lowest-number rule covers duplicates. The random stimulus therefore writes arbitrary control bytes, which produces such collisions on purpose. The mask words it draws are sparse, so that requests still get through, and about one draw in eight sets the mask-all bit.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int NUM_SLOTS      = 64;
  localparam int SRC_W          = $clog2(NUM_SLOTS);
  localparam int LVL_W          = 3;
  localparam int PRI_W          = 3;
  localparam int KEY_W          = LVL_W + PRI_W;
  localparam int BUS_W          = 32;
  localparam int BYTES_PER_WORD = BUS_W / 8;
  localparam int MASK_WORDS     = NUM_SLOTS / BUS_W;
  localparam int CTRL_WORDS     = NUM_SLOTS / BYTES_PER_WORD;

  // One candidate in the arbitration tree: key is {level, priority}.
  typedef struct packed {
    logic             vld;
    logic [KEY_W-1:0] key;
    logic [SRC_W-1:0] idx;
  } arb_node_t;
endpackage

// File: rtl/pic_regs.sv
module pic_regs
  import pic_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int MASK_BASE = 0,
  parameter int CTRL_BASE = 16,
  parameter int NUM_FIXED = 7,
  parameter int FIXED_PRI = 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             wr_en,
  input  logic                             rd_en,
  input  logic [ADDR_W-1:0]                addr,
  input  logic [BYTES_PER_WORD-1:0]        be,
  input  logic [BUS_W-1:0]                 wdata,
  output logic [BUS_W-1:0]                 rdata,
  output logic [NUM_SLOTS-1:0]             src_mask,
  output logic                             mask_all,
  output logic [NUM_SLOTS-1:0][KEY_W-1:0]  src_key
);

  logic [MASK_WORDS-1:0][BUS_W-1:0] mask_q;
  logic [BUS_W-1:0]                 rd_word;

  genvar w, s;
  generate
    for (w = 0; w < MASK_WORDS; w++) begin : g_mask
      localparam logic [ADDR_W-1:0] WADDR = ADDR_W'(MASK_BASE + w);
      logic [BUS_W-1:0] word_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          word_q <= '1;
        end else if (wr_en && addr == WADDR) begin
          for (int b = 0; b < BYTES_PER_WORD; b++) begin
            if (be[b]) word_q[8*b +: 8] <= wdata[8*b +: 8];
          end
        end
      end
      assign mask_q[w] = word_q;
    end

    for (s = 0; s < NUM_SLOTS; s++) begin : g_ctrl
      localparam logic [ADDR_W-1:0] CADDR = ADDR_W'(CTRL_BASE + s / BYTES_PER_WORD);
      localparam int LANE = s % BYTES_PER_WORD;
      if (s == 0) begin : g_empty
        assign src_key[s] = '0;
      end else if (s <= NUM_FIXED) begin : g_fixed
        assign src_key[s] = {LVL_W'(s), PRI_W'(FIXED_PRI)};
      end else begin : g_prog
        logic [KEY_W-1:0] key_q;
        always_ff @(posedge clk) begin
          if (rst) begin
            key_q <= '0;
          end else if (wr_en && addr == CADDR && be[LANE]) begin
            key_q <= wdata[8*LANE +: KEY_W];
          end
        end
        assign src_key[s] = key_q;
      end
    end
  endgenerate

  // Bit 0 of the low word is the global block, not a source mask.
  assign mask_all = mask_q[0][0];
  assign src_mask = mask_q | NUM_SLOTS'(1);

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < MASK_WORDS; i++) begin
      if (addr == ADDR_W'(MASK_BASE + i)) rd_word = mask_q[i];
    end
    for (int i = 0; i < CTRL_WORDS; i++) begin
      if (addr == ADDR_W'(CTRL_BASE + i)) begin
        for (int b = 0; b < BYTES_PER_WORD; b++) begin
          rd_word[8*b +: 8] = 8'(src_key[i*BYTES_PER_WORD + b]);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_en ? rd_word : '0;
  end

endmodule

// File: rtl/pic_arb.sv
module pic_arb
  import pic_pkg::*;
(
  input  logic [NUM_SLOTS-1:0]            req,
  input  logic [NUM_SLOTS-1:0][KEY_W-1:0] key,
  output arb_node_t                       win
);

  localparam int DEPTH = $clog2(NUM_SLOTS);

  genvar st, j;
  generate
    for (st = 0; st <= DEPTH; st++) begin : g_st
      localparam int CNT = NUM_SLOTS >> st;
      arb_node_t node [CNT];
      for (j = 0; j < CNT; j++) begin : g_n
        if (st == 0) begin : g_leaf
          assign node[j] = '{vld: req[j], key: key[j], idx: SRC_W'(j)};
        end else begin : g_cmp
          arb_node_t lo, hi;
          assign lo = g_st[st-1].node[2*j];
          assign hi = g_st[st-1].node[2*j+1];
          // The lower-numbered half wins unless the upper one is strictly better.
          assign node[j] = (hi.vld && (!lo.vld || hi.key > lo.key)) ? hi : lo;
        end
      end
    end
  endgenerate

  assign win = g_st[DEPTH].node[0];

endmodule

// File: rtl/pic_top.sv
module pic_top
  import pic_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int MASK_BASE = 0,
  parameter int CTRL_BASE = 16,
  parameter int NUM_FIXED = 7,
  parameter int FIXED_PRI = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_SLOTS-1:0]      irq_in,
  input  logic                      wr_en,
  input  logic                      rd_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [BYTES_PER_WORD-1:0] be,
  input  logic [BUS_W-1:0]          wdata,
  output logic [BUS_W-1:0]          rdata,
  output logic [LVL_W-1:0]          irq_level,
  output logic [SRC_W-1:0]          irq_src
);

  logic [NUM_SLOTS-1:0]            src_mask;
  logic                            mask_all;
  logic [NUM_SLOTS-1:0][KEY_W-1:0] src_key;
  logic [NUM_SLOTS-1:0]            eligible;
  arb_node_t                       win;

  pic_regs #(
    .ADDR_W   (ADDR_W),
    .MASK_BASE(MASK_BASE),
    .CTRL_BASE(CTRL_BASE),
    .NUM_FIXED(NUM_FIXED),
    .FIXED_PRI(FIXED_PRI)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .be      (be),
    .wdata   (wdata),
    .rdata   (rdata),
    .src_mask(src_mask),
    .mask_all(mask_all),
    .src_key (src_key)
  );

  genvar i;
  generate
    for (i = 0; i < NUM_SLOTS; i++) begin : g_elig
      assign eligible[i] = irq_in[i] && !src_mask[i] && !mask_all &&
                           (src_key[i][KEY_W-1 -: LVL_W] != '0);
    end
  endgenerate

  pic_arb u_arb (
    .req(eligible),
    .key(src_key),
    .win(win)
  );

  always_ff @(posedge clk) begin
    if (rst || !win.vld) begin
      irq_level <= '0;
      irq_src   <= '0;
    end else begin
      irq_level <= win.key[KEY_W-1 -: LVL_W];
      irq_src   <= win.idx;
    end
  end

endmodule

// File: rtl/pic_checker.sv
module pic_checker
  import pic_pkg::*;
(
  input logic                            clk,
  input logic                            rst,
  input logic [NUM_SLOTS-1:0]            irq_in,
  input logic                            rd_en,
  input logic [BUS_W-1:0]                rdata,
  input logic [LVL_W-1:0]                irq_level,
  input logic [SRC_W-1:0]                irq_src,
  input logic [NUM_SLOTS-1:0]            src_mask,
  input logic                            mask_all,
  input logic [NUM_SLOTS-1:0][KEY_W-1:0] src_key,
  input logic [NUM_SLOTS-1:0]            eligible,
  input arb_node_t                       win
);

  logic [NUM_SLOTS-1:0]            prev_in;
  logic [NUM_SLOTS-1:0]            prev_mask;
  logic [NUM_SLOTS-1:0][KEY_W-1:0] prev_key;

  always_ff @(posedge clk) begin
    prev_in   <= irq_in;
    prev_mask <= src_mask;
    prev_key  <= src_key;
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (irq_level == '0 && irq_src == '0));

  p_winner_unmasked_r2: assert property (@(posedge clk) disable iff (rst)
    (irq_level != '0) |-> (prev_in[irq_src] && !prev_mask[irq_src]));

  p_mask_all_r3: assert property (@(posedge clk) disable iff (rst)
    mask_all |=> (irq_level == '0));

  p_level_matches_r5: assert property (@(posedge clk) disable iff (rst)
    (irq_level != '0) |-> (prev_key[irq_src][KEY_W-1 -: LVL_W] == irq_level));

  p_tree_leaf_r6: assert property (@(posedge clk) disable iff (rst)
    win.vld |-> (eligible[win.idx] && win.key == src_key[win.idx]));

  p_tree_any_r6: assert property (@(posedge clk) disable iff (rst)
    win.vld == (|eligible));

  p_no_slot0_r9: assert property (@(posedge clk) disable iff (rst)
    (irq_level != '0) |-> (irq_src != '0));

  p_rd_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rdata == '0));

endmodule

bind pic_top pic_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .irq_in   (irq_in),
  .rd_en    (rd_en),
  .rdata    (rdata),
  .irq_level(irq_level),
  .irq_src  (irq_src),
  .src_mask (src_mask),
  .mask_all (mask_all),
  .src_key  (src_key),
  .eligible (eligible),
  .win      (win)
);

// File: tb/test_pic_top.sv
`timescale 1ns/1ps
module test_pic_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] irq_in = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [2:0]  irq_level;
  logic [5:0]  irq_src;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] m_mask [2];
  logic [5:0]  m_key  [64];

  pic_top i_pic_top (
    .clk(clk), .rst(rst), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .be(be), .wdata(wdata), .rdata(rdata),
    .irq_level(irq_level), .irq_src(irq_src)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] key_of(input int s);
    if (s == 0) return 6'd0;
    if (s <= 7) return {3'(s), 3'd4};
    return m_key[s];
  endfunction

  function automatic logic [8:0] model_out(input logic [63:0] rq);
    int best = -1;
    logic [5:0] bk = '0;
    for (int s = 1; s < 64; s++) begin
      logic [5:0] k;
      k = key_of(s);
      if (rq[s] && !m_mask[s/32][s%32] && !m_mask[0][0] && k[5:3] != 3'd0 &&
          (best < 0 || k > bk)) begin
        best = s;
        bk = k;
      end
    end
    return (best < 0) ? 9'd0 : {bk[5:3], 6'(best)};
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [3:0] b, input logic [31:0] d);
    addr = 5'(a); be = b; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; be = '0;
    if (a < 2) begin
      for (int k = 0; k < 4; k++) if (b[k]) m_mask[a][8*k +: 8] = d[8*k +: 8];
    end else if (a >= 16 && a < 32) begin
      for (int k = 0; k < 4; k++) begin
        int s;
        s = (a - 16) * 4 + k;
        if (b[k] && s > 7) m_key[s] = d[8*k +: 6];
      end
    end
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    addr = 5'(a); rd_en = 1'b1;
    @(negedge clk);
    d = rdata; rd_en = 1'b0;
  endtask

  task automatic chk_out(input string tag, input logic [2:0] el, input logic [5:0] es);
    chk({irq_level, irq_src} == {el, es}, tag, 32'({irq_level, irq_src}), 32'({el, es}));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [8:0]  e;
    void'($urandom(32'd42));
    m_mask[0] = '1; m_mask[1] = '1;
    for (int s = 0; s < 64; s++) m_key[s] = '0;
    irq_in = '1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    step();
    chk_out("R1 idle after reset", 3'd0, 6'd0);
    chk(rdata == 32'd0, "R1 rdata reset", rdata, 32'd0);
    rd(0, d); chk(d == 32'hFFFFFFFF, "R1 mask low reset", d, 32'hFFFFFFFF);
    rd(1, d); chk(d == 32'hFFFFFFFF, "R1 mask high reset", d, 32'hFFFFFFFF);
    rd(20, d); chk(d == 32'd0, "R1 ctrl reset", d, 32'd0);
    step(); chk(rdata == 32'd0, "R11 rdata zero without read", rdata, 32'd0);
    rd(9, d); chk(d == 32'd0, "R11 unmapped reads zero", d, 32'd0);

    rd(16, d); chk(d == 32'h1C140C00, "R8 R9 fixed bytes 0-3", d, 32'h1C140C00);
    rd(17, d); chk(d == 32'h3C342C24, "R8 fixed bytes 4-7", d, 32'h3C342C24);
    wr(16, 4'hF, 32'hFFFFFFFF);
    rd(16, d); chk(d == 32'h1C140C00, "R8 fixed write ignored", d, 32'h1C140C00);

    wr(20, 4'b0101, 32'hFFEEDDCC);
    rd(20, d); chk(d == 32'h002E000C, "R4 R10 lane write", d, 32'h002E000C);

    irq_in = '0;
    wr(0, 4'hF, 32'd0);
    wr(1, 4'hF, 32'd0);
    irq_in[16] = 1'b1;
    chk_out("R7 no change before edge", 3'd0, 6'd0);
    step(); chk_out("R7 one cycle to request", 3'd1, 6'd16);
    irq_in[16] = 1'b0;
    step(); chk_out("R7 drop deasserts", 3'd0, 6'd0);

    irq_in = '0; irq_in[20] = 1'b1;
    step(); chk_out("R5 level zero silent", 3'd0, 6'd0);
    irq_in = '0; irq_in[0] = 1'b1;
    step(); chk_out("R9 slot zero silent", 3'd0, 6'd0);

    wr(21, 4'hF, 32'h00003D3D);
    irq_in = '0; irq_in[7] = 1'b1; irq_in[20] = 1'b1; irq_in[21] = 1'b1;
    step(); chk_out("R6 tie lower source", 3'd7, 6'd20);
    irq_in[20] = 1'b0;
    step(); chk_out("R6 priority beats fixed", 3'd7, 6'd21);
    irq_in = '0; irq_in[7] = 1'b1; irq_in[16] = 1'b1;
    step(); chk_out("R6 level dominates", 3'd7, 6'd7);

    irq_in = '0; irq_in[21] = 1'b1;
    wr(0, 4'hF, 32'h00200000);
    step(); chk_out("R2 low mask blocks", 3'd0, 6'd0);
    wr(0, 4'hF, 32'd0);
    wr(26, 4'b0001, 32'h0000002A);
    irq_in = '0; irq_in[40] = 1'b1;
    step(); chk_out("R2 high source unmasked", 3'd5, 6'd40);
    wr(1, 4'hF, 32'h00000100);
    step(); chk_out("R2 high mask blocks", 3'd0, 6'd0);
    rd(1, d); chk(d == 32'h00000100, "R2 high mask readback", d, 32'h00000100);
    wr(1, 4'hF, 32'd0);
    wr(0, 4'hF, 32'd1);
    step(); chk_out("R3 mask all blocks", 3'd0, 6'd0);
    rd(0, d); chk(d == 32'd1, "R3 mask all readback", d, 32'd1);
    wr(0, 4'hF, 32'd0);
    step(); chk_out("R3 release mask all", 3'd5, 6'd40);

    for (int it = 0; it < 400; it++) begin
      int r;
      r = int'($urandom % 10);
      if (r < 6) wr(16 + int'($urandom % 16), 4'($urandom), $urandom);
      else if (r < 9) wr(int'($urandom % 2), 4'($urandom), $urandom & $urandom & $urandom);
      irq_in = {$urandom, $urandom} & {$urandom, $urandom};
      step();
      e = model_out(irq_in);
      chk_out("R6 random arbitration", e[8:6], e[5:0]);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule